// File: doc/BRIEF.md
# Synchronized Up/Clear Event Counter

This block counts events that arrive on two unrelated asynchronous wires. One wire advances the count and the other zeroes it. Each raw wire passes through a multi-flop synchronizer that runs on the free-running system clock. A rising-edge detector then turns each synchronized level into a pulse one clock wide. The two pulses feed one count register, and a single clocked process writes that register. No value is ever updated from two clock domains, and no register has two drivers.

A build-time mode selects how a clear is applied. In immediate mode the clear zeroes the count as soon as its edge has been synchronized. In deferred mode the clear edge only arms an internal pending flag. The next count edge then loads zero in place of an increment and disarms the flag. An optional wrap output pulses when the count rolls over from all ones to zero.

There is no streaming data path, so every pin is a plain control or status wire. Each input must stay high for at least two system clock periods, and then low for at least two, to be taken as one edge. Shorter pulses may be lost.

Top module: `edge_event_counter`

## Requirements
- R1: A rising edge on `inc_in` raises `count_o` by one. The new value appears on the third rising clock edge after the first clock edge that samples the input high.
- R2: In immediate mode (`CLR_MODE` = `CLR_NOW`), a rising edge on `clr_in` makes `count_o` zero, with the same latency as R1.
- R3: In immediate mode, a count edge and a clear edge that are detected in the same cycle leave `count_o` at zero.
- R4: In deferred mode (`CLR_MODE` = `CLR_ON_NEXT`), a clear edge on its own leaves `count_o` unchanged and arms a pending clear. Further clear edges while the clear is armed change nothing. The next count edge loads zero in place of an increment and disarms the pending clear, so the count edge after that gives 1.
- R5: In deferred mode, a count edge and a clear edge detected in the same cycle load zero and leave the pending clear disarmed.
- R6: When `WRAP_EN` = 1, an increment from the all-ones value gives zero and raises `wrap_o` for exactly one cycle. That cycle is the first cycle in which `count_o` shows zero. A load of zero caused by a clear never raises `wrap_o`.
- R7: Falling edges, and levels held for any length of time, leave `count_o` unchanged. An input held high for many cycles counts as one edge.
- R8: While `rst` is high at a clock edge, the count, the pending clear, the wrap output and every synchronizer and edge-detector stage are cleared. After reset a count edge gives 1 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_in | input | 1 | Asynchronous count input, rising edge counts |
| clr_in | input | 1 | Asynchronous clear input, rising edge clears |
| count_o | output | CNT_W | Current count |
| wrap_o | output | 1 | One-cycle pulse on rollover from all ones to zero |

## Verification
Every result is measured from the first clock edge that samples a raised input. The synchronizer takes two edges and the count register one more, so a changed `count_o` or a raised `wrap_o` is due right after the third edge. The bench drives its inputs on a falling edge, waits three rising edges and samples on the next falling edge. It samples once more a cycle later to confirm that `wrap_o` has dropped, and again three edges after the inputs fall to confirm that the falling edges left the count alone.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic {
    CLR_NOW     = 1'b0,
    CLR_ON_NEXT = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[LAST];
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign pulse = lvl & ~lvl_d;

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/count_core.sv
module count_core
  import evc_pkg::*;
#(
  parameter int        W       = 16,
  parameter clr_mode_e MODE    = CLR_NOW,
  parameter bit        WRAP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_p,
  input  logic         clr_p,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_n;
  logic [W:0]   sum;
  logic         pend, pend_n, wrap_n;

  assign sum = {1'b0, cnt} + {{W{1'b0}}, 1'b1};

  always_comb begin
    cnt_n  = cnt;
    pend_n = pend;
    wrap_n = 1'b0;
    if (MODE == CLR_NOW) begin
      pend_n = 1'b0;
      if (clr_p) begin
        cnt_n = ZERO;
      end else if (inc_p) begin
        cnt_n  = sum[W-1:0];
        wrap_n = sum[W];
      end
    end else begin
      if (inc_p) begin
        if (clr_p || pend) begin
          cnt_n  = ZERO;
          pend_n = 1'b0;
        end else begin
          cnt_n  = sum[W-1:0];
          wrap_n = sum[W];
        end
      end else if (clr_p) begin
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= ZERO;
      pend <= 1'b0;
      wrap <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      pend <= pend_n;
      wrap <= WRAP_EN ? wrap_n : 1'b0;
    end
  end

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_p && !clr_p && !pend) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R2
  clr_now_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == CLR_NOW && clr_p) |=> (cnt == ZERO));

  // R4
  defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == CLR_ON_NEXT && clr_p && !inc_p) |=> (pend && $stable(cnt)));

  // R5
  defer_both_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == CLR_ON_NEXT && clr_p && inc_p) |=> (cnt == ZERO && !pend));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (cnt == ZERO));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_p && !clr_p) |=> $stable(cnt));
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import evc_pkg::*;
#(
  parameter int        CNT_W       = 16,
  parameter int        SYNC_STAGES = 2,
  parameter clr_mode_e CLR_MODE    = CLR_NOW,
  parameter bit        WRAP_EN     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_in,
  input  logic             clr_in,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic inc_lvl, clr_lvl, inc_p, clr_p;

  sync_chain #(.STAGES(SYNC_STAGES)) u_inc_sync (
    .clk(clk), .rst(rst), .din(inc_in), .dout(inc_lvl));
  sync_chain #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst(rst), .din(clr_in), .dout(clr_lvl));

  rise_pulse u_inc_edge (.clk(clk), .rst(rst), .lvl(inc_lvl), .pulse(inc_p));
  rise_pulse u_clr_edge (.clk(clk), .rst(rst), .lvl(clr_lvl), .pulse(clr_p));

  count_core #(.W(CNT_W), .MODE(CLR_MODE), .WRAP_EN(WRAP_EN)) u_core (
    .clk(clk), .rst(rst), .inc_p(inc_p), .clr_p(clr_p),
    .cnt(count_o), .wrap(wrap_o));

  // R3
  both_now_chk: assert property (@(posedge clk) disable iff (rst)
    (CLR_MODE == CLR_NOW && inc_p && clr_p) |=> (count_o == '0 && !wrap_o));
endmodule

// File: tb/edge_event_counter_test.sv
module edge_event_counter_test;
  import evc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WI = 4;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc_in = 1'b0;
  logic clr_in = 1'b0;
  logic [WI-1:0] cnt_i;
  logic [WD-1:0] cnt_d;
  logic wrap_i, wrap_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [WI-1:0] exp_i;
  logic [WD-1:0] exp_d;
  bit pend_d;
  bit ewrap_i, ewrap_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_event_counter #(.CNT_W(WI), .CLR_MODE(CLR_NOW)) uut (
    .clk(clk), .rst(rst), .inc_in(inc_in), .clr_in(clr_in),
    .count_o(cnt_i), .wrap_o(wrap_i));

  edge_event_counter #(.CNT_W(WD), .CLR_MODE(CLR_ON_NEXT)) uut_dfr (
    .clk(clk), .rst(rst), .inc_in(inc_in), .clr_in(clr_in),
    .count_o(cnt_d), .wrap_o(wrap_d));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WI-1:0] next_i(input logic [WI-1:0] c, input bit inc, input bit clr);
    if (clr) return '0;
    if (inc) return c + 1'b1;
    return c;
  endfunction

  function automatic logic [WD-1:0] next_d(input logic [WD-1:0] c, input bit p, input bit inc, input bit clr);
    if (inc && (clr || p)) return '0;
    if (inc) return c + 1'b1;
    return c;
  endfunction

  function automatic bit next_pend(input bit p, input bit inc, input bit clr);
    if (inc) return 1'b0;
    if (clr) return 1'b1;
    return p;
  endfunction

  task automatic model(input bit inc, input bit clr);
    ewrap_i = inc && !clr && (exp_i == {WI{1'b1}});
    ewrap_d = inc && !clr && !pend_d && (exp_d == {WD{1'b1}});
    exp_i  = next_i(exp_i, inc, clr);
    exp_d  = next_d(exp_d, pend_d, inc, clr);
    pend_d = next_pend(pend_d, inc, clr);
  endtask

  task automatic slot(input bit inc, input bit clr, input int hold, input string tag);
    @(negedge clk);
    inc_in = inc;
    clr_in = clr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model(inc, clr);
    check({tag, " count imm"}, 32'(cnt_i), 32'(exp_i));
    check({tag, " count dfr"}, 32'(cnt_d), 32'(exp_d));
    check("R6 wrap imm", 32'(wrap_i), 32'(ewrap_i));
    check("R6 wrap dfr", 32'(wrap_d), 32'(ewrap_d));
    @(negedge clk);
    check("R6 wrap width", 32'({wrap_i, wrap_d}), 32'd0);
    repeat (hold) @(negedge clk);
    check("R7 held level imm", 32'(cnt_i), 32'(exp_i));
    inc_in = 1'b0;
    clr_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 falling imm", 32'(cnt_i), 32'(exp_i));
    check("R7 falling dfr", 32'(cnt_d), 32'(exp_d));
  endtask

  task automatic do_reset();
    @(negedge clk);
    inc_in = 1'b0;
    clr_in = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 reset count imm", 32'(cnt_i), 32'd0);
    check("R8 reset count dfr", 32'(cnt_d), 32'd0);
    check("R8 reset wrap", 32'({wrap_i, wrap_d}), 32'd0);
    rst = 1'b0;
    exp_i = '0;
    exp_d = '0;
    pend_d = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_i = '0;
    exp_d = '0;
    pend_d = 1'b0;
    do_reset();

    slot(1'b1, 1'b0, 0, "R1");
    slot(1'b1, 1'b0, 0, "R1");
    slot(1'b0, 1'b1, 0, "R2 R4");
    check("R4 pending holds dfr", 32'(cnt_d), 32'd2);
    slot(1'b0, 1'b1, 0, "R4 second clear");
    slot(1'b1, 1'b0, 0, "R4 clear on count");
    check("R4 loaded zero dfr", 32'(cnt_d), 32'd0);
    slot(1'b1, 1'b0, 0, "R4 disarmed");
    check("R4 next count dfr", 32'(cnt_d), 32'd1);
    slot(1'b1, 1'b1, 0, "R3 R5 both");
    check("R3 both imm", 32'(cnt_i), 32'd0);
    slot(1'b1, 1'b0, 0, "R5 not armed");
    check("R5 not armed dfr", 32'(cnt_d), 32'd1);

    slot(1'b0, 1'b1, 0, "R6 prep");
    for (int k = 0; k < (1 << WI); k++) slot(1'b1, 1'b0, 0, "R6 walk");
    check("R6 wrapped imm", 32'(cnt_i), 32'd0);

    slot(1'b1, 1'b0, 12, "R7 long hold");

    slot(1'b0, 1'b1, 0, "R8 arm");
    do_reset();
    slot(1'b1, 1'b0, 0, "R8 after reset");
    check("R8 first count dfr", 32'(cnt_d), 32'd1);
    check("R8 first count imm", 32'(cnt_i), 32'd1);

    for (int s = 0; s < 400; s++) begin
      int r;
      r = int'($urandom % 8);
      case (r)
        0, 1, 2, 3, 4: slot(1'b1, 1'b0, int'($urandom % 3), "R1 rand");
        5:             slot(1'b0, 1'b1, int'($urandom % 3), "R2 R4 rand");
        6:             slot(1'b1, 1'b1, 0, "R3 R5 rand");
        default:       slot(1'b0, 1'b0, 0, "R7 rand");
      endcase
      if (s == 200) do_reset();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule